// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects the interrupt requests of a small processor subsystem and turns them into a request line and a 16-bit vector address for the CPU. It handles two classes of request. The first class has a single request with its own mask bit and the highest rank. The second class is made up of one external request line and a parameterised set of peripheral requests, all of which share a common mask bit. The upper byte of every vector comes from a programmable base register. The lower byte names the winning source. When the CPU fetches a vector and no request qualifies, the block returns a fixed spurious vector.

The block is built around a three-state controller. In `ST_RUN` it raises `cpu_irq` whenever a qualified request is present. The transition RUN→FETCH happens when `vec_fetch` is seen. It latches the vector, which then stays frozen for as long as `vec_fetch` is held, and the transition FETCH→RUN happens when the strobe drops. The transition RUN→STOP happens when `stop_mode` is asserted, and STOP→RUN happens when it is removed. While stopped, the wake-up output is formed by gates only, straight from the raw request pins. It therefore needs no clock.

Request pins are level-sensitive and are resynchronised by two flops before they reach the priority logic. The CPU mask bits are used as they arrive, without resynchronisation.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the base register holds 0xFF, `vec_addr` is 0xFF80 and `cpu_irq` is low.
- R2: A write on the base port replaces the base at the clock edge where `base_wr_en` is high. A fetch accepted at that same edge still uses the old base. Every vector is `{base, low_byte}`.
- R3: The X-class request has low byte 0xF4 and wins over every I-class request.
- R4: Among I-class requests, the external request (low byte 0xF2) wins over the peripheral sources. Peripheral source k has low byte 0xF0 − 2·k, and a lower index wins.
- R5: While `cpu_i_mask` is 1, I-class requests neither raise `cpu_irq` nor select a vector. While `cpu_x_mask` is 1, the X-class request does neither.
- R6: A fetch accepted while no request qualifies yields the low byte 0x80.
- R7: A request level that is present before clock edge k is seen by `cpu_irq` and by vector selection from edge k+1 onward.
- R8: In `ST_RUN`, with `stop_mode` low, `vec_fetch` high latches the vector at the clock edge and moves the controller to `ST_FETCH`. In `ST_FETCH`, `vec_addr` is held and `cpu_irq` is low. The controller returns to `ST_RUN` at the first edge where `vec_fetch` is low.
- R9: In `ST_RUN`, a high `stop_mode` moves the controller to `ST_STOP`, even if a fetch is requested. While `stop_mode` is high, `cpu_irq` is low.
- R10: While `stop_mode` is high, `wakeup` follows the raw pins with no clock edge. It is the OR of the X-class pin and (any I-class pin AND NOT `cpu_i_mask`).
- R11: The X-class pin wakes the block even when `cpu_x_mask` is 1. After `stop_mode` drops with that mask still set, `cpu_irq` stays low.
- R12: `wakeup` is low whenever `stop_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Write strobe for the vector base register |
| base_wr_data | input | 8 | New upper byte of the vector table |
| irq_x_req | input | 1 | X-class request, level-sensitive |
| irq_ext_req | input | 1 | External I-class request, level-sensitive |
| irq_src_req | input | N_SRC | Peripheral I-class requests; bit 0 has the highest rank |
| cpu_i_mask | input | 1 | CPU I mask bit (1 = masked) |
| cpu_x_mask | input | 1 | CPU X mask bit (1 = masked) |
| vec_fetch | input | 1 | CPU vector-fetch strobe |
| stop_mode | input | 1 | CPU is in stop mode |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Latched vector address |
| wakeup | output | 1 | Clock-free wake-up request |

## Verification
The base write and the vector fetch can land on the same clock edge. The bench provokes this by raising `base_wr_en` in the cycle that a fetch is accepted. It then expects the old base in that vector and the new base in the next one. A second collision pits `stop_mode` against `vec_fetch` in `ST_RUN`. Here the model expects the move to stop and an unchanged vector. A behavioural model predicts `cpu_irq`, `wakeup` and `vec_addr` on every cycle, and each prediction is compared with the design.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FETCH = 2'd1,
        ST_STOP  = 2'd2
    } vec_state_e;

    localparam logic [7:0] LB_X       = 8'hF4;
    localparam logic [7:0] LB_EXT     = 8'hF2;
    localparam logic [7:0] LB_SRC_TOP = 8'hF0;
    localparam logic [7:0] LB_SPUR    = 8'h80;
    localparam logic [7:0] BASE_RST   = 8'hFF;

    // Low byte of peripheral source k: two bytes per vector, counting down.
    function automatic logic [7:0] src_low(input int k);
        return LB_SRC_TOP - 8'(2 * k);
    endfunction

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[b] <= 1'b0;
                stage2_q[b] <= 1'b0;
            end else begin
                stage1_q[b] <= d_async[b];
                stage2_q[b] <= stage1_q[b];
            end
        end
    end

    assign q_sync = stage2_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_vec_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             x_req,
    input  logic             ext_req,
    input  logic [N_SRC-1:0] src_req,
    input  logic             i_mask,
    input  logic             x_mask,
    output logic             x_valid,
    output logic             any_valid,
    output logic [7:0]       low_byte
);
    logic       i_valid;
    logic [7:0] i_byte;

    always_comb begin
        i_byte = LB_SPUR;
        // Walk from the lowest rank upward so the highest rank is written last.
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (src_req[k]) i_byte = src_low(k);
        end
        if (ext_req) i_byte = LB_EXT;

        i_valid   = (ext_req | (|src_req)) & ~i_mask;
        x_valid   = x_req & ~x_mask;
        any_valid = x_valid | i_valid;

        if (x_valid)      low_byte = LB_X;
        else if (i_valid) low_byte = i_byte;
        else              low_byte = LB_SPUR;
    end
endmodule

// File: rtl/irq_wake_logic.sv
module irq_wake_logic #(
    parameter int N_SRC = 8
) (
    input  logic             stop_mode,
    input  logic             x_pin,
    input  logic             ext_pin,
    input  logic [N_SRC-1:0] src_pins,
    input  logic             i_mask,
    output logic             wakeup
);
    logic i_wake;
    logic x_wake;

    // Gates only: no storage, so this path works while the clock is stopped.
    always_comb begin
        i_wake = (ext_pin | (|src_pins)) & ~i_mask;
        x_wake = x_pin;
        wakeup = stop_mode & (i_wake | x_wake);
    end
endmodule

// File: rtl/irq_vec_fsm.sv
module irq_vec_fsm
    import irq_vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_mode,
    input  logic        vec_fetch,
    input  logic        any_valid,
    input  logic [7:0]  low_byte,
    input  logic [7:0]  base,
    output logic        cpu_irq,
    output logic [15:0] vec_addr
);
    vec_state_e  state_q;
    vec_state_e  state_d;
    logic [15:0] vec_q;
    logic        take_fetch;

    always_comb begin
        state_d    = state_q;
        take_fetch = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_mode) begin
                    state_d = ST_STOP;
                end else if (vec_fetch) begin
                    state_d    = ST_FETCH;
                    take_fetch = 1'b1;
                end
            end
            ST_FETCH: if (!vec_fetch) state_d = ST_RUN;
            ST_STOP:  if (!stop_mode) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          vec_q <= {BASE_RST, LB_SPUR};
        else if (take_fetch) vec_q <= {base, low_byte};
    end

    always_comb begin
        cpu_irq  = (state_q == ST_RUN) && !stop_mode && any_valid;
        vec_addr = vec_q;
    end

    // R8: the vector is frozen while the fetch strobe is held
    p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && vec_fetch) |=> $stable(vec_addr));

    // R8: no request to the CPU during a fetch
    p_no_irq_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> !cpu_irq);

    // R6: a fetch with nothing qualified yields the spurious entry
    p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stop_mode && vec_fetch && !any_valid)
            |=> vec_addr[7:0] == LB_SPUR);

    // R9: stop wins over a fetch request
    p_stop_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_mode) |=> (state_q == ST_STOP && $stable(vec_addr)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr_en,
    input  logic [7:0]       base_wr_data,
    input  logic             irq_x_req,
    input  logic             irq_ext_req,
    input  logic [N_SRC-1:0] irq_src_req,
    input  logic             cpu_i_mask,
    input  logic             cpu_x_mask,
    input  logic             vec_fetch,
    input  logic             stop_mode,
    output logic             cpu_irq,
    output logic [15:0]      vec_addr,
    output logic             wakeup
);
    localparam int REQ_W = N_SRC + 2;

    logic [7:0]       base_q;
    logic [REQ_W-1:0] req_sync;
    logic             x_valid;
    logic             any_valid;
    logic [7:0]       low_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          base_q <= BASE_RST;
        else if (base_wr_en) base_q <= base_wr_data;
    end

    irq_req_sync #(.W(REQ_W)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({irq_x_req, irq_ext_req, irq_src_req}),
        .q_sync  (req_sync)
    );

    irq_prio_enc #(.N_SRC(N_SRC)) enc_i (
        .x_req     (req_sync[REQ_W-1]),
        .ext_req   (req_sync[REQ_W-2]),
        .src_req   (req_sync[N_SRC-1:0]),
        .i_mask    (cpu_i_mask),
        .x_mask    (cpu_x_mask),
        .x_valid   (x_valid),
        .any_valid (any_valid),
        .low_byte  (low_byte)
    );

    irq_vec_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_mode (stop_mode),
        .vec_fetch (vec_fetch),
        .any_valid (any_valid),
        .low_byte  (low_byte),
        .base      (base_q),
        .cpu_irq   (cpu_irq),
        .vec_addr  (vec_addr)
    );

    irq_wake_logic #(.N_SRC(N_SRC)) wake_i (
        .stop_mode (stop_mode),
        .x_pin     (irq_x_req),
        .ext_pin   (irq_ext_req),
        .src_pins  (irq_src_req),
        .i_mask    (cpu_i_mask),
        .wakeup    (wakeup)
    );

    // R2: the base port loads on the write edge
    p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |=> base_q == $past(base_wr_data));

    // R3: a qualified X-class request wins the fetch
    p_x_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && vec_fetch && x_valid) |=> vec_addr[7:0] == LB_X);

    // R9: no CPU request while stopped
    p_no_irq_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> !cpu_irq);

    // R12: wake-up only in stop mode
    p_wake_stop_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |-> !wakeup);
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
    localparam int N = 8;
    localparam int W = N + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         base_wr_en = 1'b0;
    logic [7:0]   base_wr_data = 8'h00;
    logic         irq_x_req = 1'b0;
    logic         irq_ext_req = 1'b0;
    logic [N-1:0] irq_src_req = '0;
    logic         cpu_i_mask = 1'b0;
    logic         cpu_x_mask = 1'b0;
    logic         vec_fetch = 1'b0;
    logic         stop_mode = 1'b0;
    logic         cpu_irq;
    logic [15:0]  vec_addr;
    logic         wakeup;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int           m_state = 0;          // 0 run, 1 fetch, 2 stop
    logic [7:0]   m_base = 8'hFF;
    logic [15:0]  m_vec = 16'hFF80;
    logic [W-1:0] m_s1 = '0;
    logic [W-1:0] m_s2 = '0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.N_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .irq_x_req(irq_x_req), .irq_ext_req(irq_ext_req), .irq_src_req(irq_src_req),
        .cpu_i_mask(cpu_i_mask), .cpu_x_mask(cpu_x_mask), .vec_fetch(vec_fetch),
        .stop_mode(stop_mode), .cpu_irq(cpu_irq), .vec_addr(vec_addr), .wakeup(wakeup)
    );

    function automatic bit m_valid(input logic [W-1:0] s);
        bit iv = ((s[N] | (|s[N-1:0])) && !cpu_i_mask);
        bit xv = (s[N+1] && !cpu_x_mask);
        return iv || xv;
    endfunction

    function automatic logic [7:0] m_low(input logic [W-1:0] s);
        if (s[N+1] && !cpu_x_mask) return 8'hF4;
        if (!cpu_i_mask) begin
            if (s[N]) return 8'hF2;
            for (int k = 0; k < N; k++) if (s[k]) return 8'(240 - 2 * k);
        end
        return 8'h80;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        bit exp_irq;
        bit exp_wake;
        #1;
        exp_irq  = (m_state == 0) && !stop_mode && m_valid(m_s2);
        exp_wake = stop_mode && (irq_x_req || ((irq_ext_req || (|irq_src_req)) && !cpu_i_mask));
        check(tag, "cpu_irq", int'(cpu_irq), int'(exp_irq));
        check(tag, "wakeup", int'(wakeup), int'(exp_wake));
        check(tag, "vec_addr", int'(vec_addr), int'(m_vec));
        @(posedge clk);
        if (m_state == 0) begin
            if (stop_mode) m_state = 2;
            else if (vec_fetch) begin
                m_vec = {m_base, m_low(m_s2)};
                m_state = 1;
            end
        end else if (m_state == 1) begin
            if (!vec_fetch) m_state = 0;
        end else if (!stop_mode) m_state = 0;
        if (base_wr_en) m_base = base_wr_data;
        m_s2 = m_s1;
        m_s1 = {irq_x_req, irq_ext_req, irq_src_req};
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // fetch: strobe for two cycles, then release and settle
    task automatic fetch(input string tag);
        vec_fetch = 1'b1; step(tag); step(tag);
        vec_fetch = 1'b0; step(tag);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        step("R1");
        rst_n = 1'b1;
        step("R1");
        check("R1", "reset vector", int'(vec_addr), 16'hFF80);

        fetch("R6");
        check("R6", "spurious", int'(vec_addr), 16'hFF80);

        irq_src_req[3] = 1'b1;
        step("R7"); step("R7"); step("R7");
        fetch("R4");
        check("R4", "src3", int'(vec_addr), 16'hFFEA);

        irq_src_req = 8'b0010_0010;
        idle("R7", 3);
        fetch("R4");
        irq_src_req = 8'b0000_0001; irq_ext_req = 1'b1;
        idle("R4", 3);
        fetch("R4");
        check("R4", "ext", int'(vec_addr), 16'hFFF2);

        irq_x_req = 1'b1;
        idle("R3", 3);
        vec_fetch = 1'b1; step("R3");
        irq_x_req = 1'b0; irq_ext_req = 1'b0; irq_src_req = '0;
        idle("R8", 4);
        check("R8", "held", int'(vec_addr), 16'hFFF4);
        vec_fetch = 1'b0; step("R8");

        cpu_i_mask = 1'b1; irq_ext_req = 1'b1;
        idle("R5", 3);
        fetch("R5");
        cpu_x_mask = 1'b1; irq_x_req = 1'b1; cpu_i_mask = 1'b0;
        irq_ext_req = 1'b0; irq_src_req[2] = 1'b1;
        idle("R5", 3);
        fetch("R5");
        check("R5", "x masked", int'(vec_addr), 16'hFFEC);

        base_wr_en = 1'b1; base_wr_data = 8'h12; vec_fetch = 1'b1;
        step("R2");
        base_wr_en = 1'b0; step("R2");
        vec_fetch = 1'b0; step("R2");
        check("R2", "old base", int'(vec_addr), 16'hFFEC);
        fetch("R2");
        check("R2", "new base", int'(vec_addr), 16'h12EC);

        irq_x_req = 1'b0; irq_src_req = '0;
        idle("R12", 3);
        stop_mode = 1'b1; vec_fetch = 1'b1; step("R9");
        vec_fetch = 1'b0; step("R9");
        irq_src_req[5] = 1'b1; step("R10");
        cpu_i_mask = 1'b1; step("R10");
        irq_src_req = '0; irq_x_req = 1'b1; step("R11");
        idle("R11", 3);
        stop_mode = 1'b0;
        idle("R11", 4);
        cpu_x_mask = 1'b0; idle("R12", 2);
        fetch("R3");
        check("R3", "x after stop", int'(vec_addr), 16'h12F4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule